// File: doc/BRIEF.md
# Rotating Priority Resolver With In-Service Tracking

This block chooses which of eight interrupt lines should be presented to a processor next. It takes the latched request vector and the mask vector. Among the unmasked pending lines it finds the one with the best priority. It then compares that priority with the best priority among the lines already in service. The selection is raised only when the new request strictly outranks every line in service. Priority is measured against a rotation offset: the line equal to the offset is the most urgent, and urgency falls as the line number climbs, wrapping around from line 7 to line 0.

The block holds the in-service vector, the rotation offset and a flag that makes automatic end-of-interrupt rotate priority. An acknowledge strobe marks the selected line as in service. A one-cycle command port carries end-of-interrupt commands (by priority or by line, each with or without rotation), a set-lowest-priority command, and the rotate-on-auto flag updates. A nested-mode input lets the primary instance of a cascaded pair ignore its cascade line when it compares against the lines in service. Request latching and bus decoding sit outside. The ports are plain control pins with no valid/ready handshake and no back-pressure. A strobe or command is consumed in the cycle it is presented.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset the in-service vector is all zero, the rotation offset is 0 (line 0 most urgent) and rotate-on-auto is off.
- R2: The priority of line n is (n − offset) mod 8, where 0 is the most urgent. `sel_line` names the unmasked pending line with the best priority. A line whose `line_mask` bit is 1 is never selected.
- R3: `sel_valid` is 1 only when the best pending priority is strictly better than the best in-service priority. An empty in-service vector counts as priority 8. Equal or worse pending priority gives 0.
- R4: On a primary instance with `nested_en` high, in-service bit 2 (the cascade line) is left out of the comparison in R3. It is still used by the end-of-interrupt commands.
- R5: `ack` while `sel_valid` is 1 sets the in-service bit of `sel_line` at the next clock edge. `ack` while `sel_valid` is 0 has no effect.
- R6: With `auto_eoi` high, an accepted `ack` leaves the selected line's in-service bit at 0. If rotate-on-auto is on, the offset also becomes (line+1) mod 8.
- R7: Command code 1 clears the in-service bit with the best priority. Code 5 does the same and also sets the offset to (that line+1) mod 8. With nothing in service, both codes change nothing.
- R8: Command code 3 clears the in-service bit named by `cmd_arg`. Code 7 does the same and also sets the offset to (`cmd_arg`+1) mod 8.
- R9: Command code 6 sets the offset to (`cmd_arg`+1) mod 8 and leaves the in-service vector unchanged.
- R10: Command code 0 turns rotate-on-auto off and code 4 turns it on. Code 2 changes nothing. None of these three codes touches the in-service vector.
- R11: When `cmd_valid` and `ack` are high in the same cycle, the command is executed and the acknowledge is dropped.
- R12: `sel_valid` and `sel_line` follow the request, mask, nested-mode and in-service state combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pending | input | 8 | Latched request vector, one bit per line |
| line_mask | input | 8 | 1 blocks the line from selection |
| nested_en | input | 1 | Leave the cascade line out of the in-service comparison (primary only) |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| ack | input | 1 | Acknowledge strobe for the current selection |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..7 as in R7–R10) |
| cmd_arg | input | 3 | Line number or priority argument of the command |
| sel_valid | output | 1 | A selection outranks everything in service |
| sel_line | output | 3 | Selected line number |
| in_service | output | 8 | In-service vector |

## Verification
Directed patterns walk the offset to known values with code 6, then present every line pending. The selected line then shows the offset directly and separates a correct rotation from an off-by-one. An acknowledge followed by the same request shows that equal priority blocks the selection. Raising the cascade line in nested mode tells the primary exclusion apart from plain strict comparison. Random traffic mixes masks, acknowledges, auto end-of-interrupt and all eight command codes, including commands that collide with an acknowledge. A bench model checks the selection, the validity and the in-service vector every cycle, which exposes wrong clear targets and wrong rotation sources.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  // Command codes; the numeric values are part of the interface.
  typedef enum logic [2:0] {
    CMD_RA_OFF      = 3'd0,
    CMD_EOI_BEST    = 3'd1,
    CMD_IDLE        = 3'd2,
    CMD_EOI_LINE    = 3'd3,
    CMD_RA_ON       = 3'd4,
    CMD_EOI_BEST_R  = 3'd5,
    CMD_SET_LOW     = 3'd6,
    CMD_EOI_LINE_R  = 3'd7
  } rpr_cmd_e;
endpackage

// File: rtl/rpr_rot_find.sv
// Finds the best (smallest) rotated priority in a vector.
// Returns N_LINES when the vector is empty. N_LINES must be a power of two.
module rpr_rot_find #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int PRIO_W = IDX_W + 1
) (
  input  logic [N_LINES-1:0] vec,
  input  logic [IDX_W-1:0]   offset,
  output logic [PRIO_W-1:0]  prio
);
  logic [N_LINES-1:0] rot;

  // rot[k] holds the line that sits at priority k.
  for (genvar k = 0; k < N_LINES; k++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src    = IDX_W'(k) + offset;
    assign rot[k] = vec[src];
  end

  always_comb begin
    prio = PRIO_W'(N_LINES);
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (rot[k]) prio = PRIO_W'(k);
    end
  end
endmodule

// File: rtl/rpr_isr_ctrl.sv
// Holds the in-service vector, rotation offset and rotate-on-auto flag.
module rpr_isr_ctrl
  import rpr_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_eoi,
  input  logic               ack,
  input  logic               sel_valid,
  input  logic [IDX_W-1:0]   sel_line,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [IDX_W-1:0]   cmd_arg,
  input  logic               best_isr_found,
  input  logic [IDX_W-1:0]   best_isr_line,
  output logic [N_LINES-1:0] isr_q,
  output logic [IDX_W-1:0]   offset_q
);
  logic               rot_auto_q, rot_auto_d;
  logic [N_LINES-1:0] isr_d;
  logic [IDX_W-1:0]   offset_d;
  rpr_cmd_e           op;

  assign op = rpr_cmd_e'(cmd_op);

  always_comb begin
    isr_d      = isr_q;
    offset_d   = offset_q;
    rot_auto_d = rot_auto_q;
    if (cmd_valid) begin
      unique case (op)
        CMD_RA_OFF: rot_auto_d = 1'b0;
        CMD_RA_ON:  rot_auto_d = 1'b1;
        CMD_IDLE:   ;
        CMD_EOI_BEST: begin
          if (best_isr_found) isr_d[best_isr_line] = 1'b0;
        end
        CMD_EOI_BEST_R: begin
          if (best_isr_found) begin
            isr_d[best_isr_line] = 1'b0;
            offset_d             = best_isr_line + IDX_W'(1);
          end
        end
        CMD_EOI_LINE: isr_d[cmd_arg] = 1'b0;
        CMD_EOI_LINE_R: begin
          isr_d[cmd_arg] = 1'b0;
          offset_d       = cmd_arg + IDX_W'(1);
        end
        CMD_SET_LOW: offset_d = cmd_arg + IDX_W'(1);
        default: ;
      endcase
    end else if (ack && sel_valid) begin
      if (!auto_eoi) begin
        isr_d[sel_line] = 1'b1;
      end else begin
        isr_d[sel_line] = 1'b0;
        if (rot_auto_q) offset_d = sel_line + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q      <= '0;
      offset_q   <= '0;
      rot_auto_q <= 1'b0;
    end else begin
      isr_q      <= isr_d;
      offset_q   <= offset_d;
      rot_auto_q <= rot_auto_d;
    end
  end

  // R5: an accepted acknowledge without auto EOI marks the line in service
  a_r5_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sel_valid && !cmd_valid && !auto_eoi) |=> isr_q[$past(sel_line)]);

  // R6: with auto EOI the acknowledged line does not stay in service
  a_r6_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sel_valid && !cmd_valid && auto_eoi) |=> !isr_q[$past(sel_line)]);

  // R9 and R10: codes 0, 2, 4 and 6 keep the in-service vector
  a_r10_isr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd4 || cmd_op == 3'd6))
    |=> $stable(isr_q));

  // R8: a line-specific EOI leaves the named bit clear
  a_r8_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd7)) |=> !isr_q[$past(cmd_arg)]);

  // R7: an EOI by priority with nothing in service changes nothing
  a_r7_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd5) && isr_q == '0)
    |=> (isr_q == '0 && $stable(offset_q)));
endmodule

// File: rtl/rot_prio_resolver.sv
// Top: rotating priority resolver with in-service tracking.
module rot_prio_resolver #(
  parameter int N_LINES      = 8,
  parameter bit IS_PRIMARY   = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W       = $clog2(N_LINES),
  localparam int PRIO_W      = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_pending,
  input  logic [N_LINES-1:0] line_mask,
  input  logic               nested_en,
  input  logic               auto_eoi,
  input  logic               ack,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [IDX_W-1:0]   cmd_arg,
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_line,
  output logic [N_LINES-1:0] in_service
);
  logic [N_LINES-1:0] live_req;
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] isr_cmp;
  logic [IDX_W-1:0]   offset_q;
  logic [PRIO_W-1:0]  req_prio, cmp_prio, raw_prio;
  logic               best_isr_found;
  logic [IDX_W-1:0]   best_isr_line;

  assign live_req = req_pending & ~line_mask;

  // Nested-mode exclusion exists only on the primary instance.
  if (IS_PRIMARY) begin : g_primary
    logic [N_LINES-1:0] cascade_bit;
    assign cascade_bit = N_LINES'(1) << CASCADE_LINE;
    assign isr_cmp     = nested_en ? (isr_q & ~cascade_bit) : isr_q;
  end else begin : g_secondary
    assign isr_cmp = isr_q;
  end

  rpr_rot_find #(.N_LINES(N_LINES)) u_find_req (
    .vec(live_req), .offset(offset_q), .prio(req_prio));

  rpr_rot_find #(.N_LINES(N_LINES)) u_find_cmp (
    .vec(isr_cmp), .offset(offset_q), .prio(cmp_prio));

  rpr_rot_find #(.N_LINES(N_LINES)) u_find_raw (
    .vec(isr_q), .offset(offset_q), .prio(raw_prio));

  // An empty set has its top bit set (priority == N_LINES).
  assign sel_valid      = req_prio < cmp_prio;
  assign sel_line       = req_prio[IDX_W-1:0] + offset_q;
  assign best_isr_found = !raw_prio[IDX_W];
  assign best_isr_line  = raw_prio[IDX_W-1:0] + offset_q;
  assign in_service     = isr_q;

  rpr_isr_ctrl #(.N_LINES(N_LINES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_eoi      (auto_eoi),
    .ack           (ack),
    .sel_valid     (sel_valid),
    .sel_line      (sel_line),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_arg       (cmd_arg),
    .best_isr_found(best_isr_found),
    .best_isr_line (best_isr_line),
    .isr_q         (isr_q),
    .offset_q      (offset_q)
  );

  // R2: a selection is always a pending, unmasked line
  a_r2_sel_live: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (req_pending[sel_line] && !line_mask[sel_line]));

  // R3: the selected line cannot already be in service (equal priority blocks)
  a_r3_strict: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !isr_cmp[sel_line]);

  // R11: a command in the same cycle drops the acknowledge
  a_r11_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ack && sel_valid && !in_service[sel_line] && cmd_op == 3'd2)
    |=> $stable(in_service));
endmodule

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_pending = '0, line_mask = '0;
  logic       nested_en = 1'b0, auto_eoi = 1'b0, ack = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_arg = '0;
  logic       sel_valid;
  logic [2:0] sel_line;
  logic [7:0] in_service;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_isr = '0;
  logic [2:0] m_off = '0;
  bit         m_ra  = 1'b0;

  always #5 clk = ~clk;

  rot_prio_resolver i_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_pending(req_pending), .line_mask(line_mask),
    .nested_en(nested_en), .auto_eoi(auto_eoi), .ack(ack), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .sel_valid(sel_valid), .sel_line(sel_line),
    .in_service(in_service));

  function automatic int best_prio(logic [7:0] v, logic [2:0] off);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] ln;
      ln = 3'(k) + off;
      if (v[ln]) return k;
    end
    return 8;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, advance model.
  task automatic step(logic [7:0] p, logic [7:0] m, bit nst, bit aeoi, bit a,
                      bit cv, logic [2:0] op, logic [2:0] arg, string tag);
    int pp, ip, bi;
    bit ev;
    logic [2:0] el, bl;
    logic [7:0] eff;
    @(negedge clk);
    req_pending = p; line_mask = m; nested_en = nst; auto_eoi = aeoi;
    ack = a; cmd_valid = cv; cmd_op = op; cmd_arg = arg;
    #1;
    eff = nst ? (m_isr & 8'hFB) : m_isr;
    pp  = best_prio(p & ~m, m_off);
    ip  = best_prio(eff, m_off);
    ev  = pp < ip;
    el  = 3'(pp) + m_off;
    check(tag, "in_service", int'(in_service), int'(m_isr));
    check(tag, "sel_valid", int'(sel_valid), int'(ev));
    if (ev) check(tag, "sel_line", int'(sel_line), int'(el));
    bi = best_prio(m_isr, m_off);
    bl = 3'(bi) + m_off;
    if (cv) begin
      case (op)
        3'd0: m_ra = 1'b0;
        3'd4: m_ra = 1'b1;
        3'd1: if (bi < 8) m_isr[bl] = 1'b0;
        3'd5: if (bi < 8) begin m_isr[bl] = 1'b0; m_off = bl + 3'd1; end
        3'd3: m_isr[arg] = 1'b0;
        3'd7: begin m_isr[arg] = 1'b0; m_off = arg + 3'd1; end
        3'd6: m_off = arg + 3'd1;
        default: ;
      endcase
    end else if (a && ev) begin
      if (!aeoi) m_isr[el] = 1'b1;
      else begin
        m_isr[el] = 1'b0;
        if (m_ra) m_off = el + 3'd1;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, line 0 most urgent
    step(8'h00, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R1");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R1");
    // R2: mask blocks lines 0..3
    step(8'hFF, 8'h0F, 0, 0, 0, 0, 3'd2, 3'd0, "R2");
    // R5: acknowledge line 0, then equal priority blocks (R3)
    step(8'h01, 8'h00, 0, 0, 1, 0, 3'd2, 3'd0, "R5");
    step(8'h01, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R3");
    step(8'h02, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R3");
    // R7: EOI by priority
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd1, 3'd0, "R7");
    // R9: offset 4 then check with all pending
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd6, 3'd3, "R9");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R9");
    // R7: rotating EOI with nothing in service
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd5, 3'd0, "R7");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R7");
    // R8: ack line 4, then rotating line EOI
    step(8'hFF, 8'h00, 0, 0, 1, 0, 3'd2, 3'd0, "R5");
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd7, 3'd4, "R8");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R8");
    // R10 and R6: rotate-on-auto on, auto EOI ack rotates
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd4, 3'd0, "R10");
    step(8'h40, 8'h00, 0, 1, 1, 0, 3'd2, 3'd0, "R6");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R6");
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd0, 3'd0, "R10");
    step(8'h40, 8'h00, 0, 1, 1, 0, 3'd2, 3'd0, "R6");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R6");
    // R4: offset 0, cascade line in service, nested mode lets it through
    step(8'h00, 8'h00, 0, 0, 0, 1, 3'd6, 3'd7, "R9");
    step(8'h04, 8'h00, 0, 0, 1, 0, 3'd2, 3'd0, "R5");
    step(8'h04, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R4");
    step(8'h04, 8'h00, 1, 0, 0, 0, 3'd2, 3'd0, "R4");
    step(8'h08, 8'h00, 1, 0, 0, 0, 3'd2, 3'd0, "R4");
    // R5: ack with nothing selectable is ignored
    step(8'h00, 8'h00, 0, 0, 1, 0, 3'd2, 3'd0, "R5");
    // R11: command and ack together; R10: code 2 changes nothing
    step(8'h01, 8'h00, 0, 0, 1, 1, 3'd2, 3'd0, "R11");
    step(8'h00, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R11");
    step(8'h01, 8'h00, 0, 0, 1, 1, 3'd3, 3'd2, "R11");
    step(8'h00, 8'h00, 0, 0, 0, 0, 3'd2, 3'd0, "R8");
    // random traffic (R2, R3, R12 and all commands)
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      bit cv;
      cv = ($urandom % 100) < 18;
      step(8'($urandom), ($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
           ($urandom % 10) < 3, ($urandom % 10) < 2, ($urandom % 2) == 1,
           cv, 3'($urandom), 3'($urandom), "R12");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule